// File: doc/BRIEF.md
# Two-Tier Preemptive Thread Dispatcher

This block decides which coprocessor channel runs next. Each channel has a 3-bit priority level. Levels 1 to 3 are the low tier, levels 4 to 7 are the high tier, and level 0 switches the channel off. A one-cycle pulse on a channel's request input marks that channel as pending. The dispatcher starts the best pending channel, holds it as the active thread until the thread-done strobe arrives, and then raises a one-cycle completion interrupt on that channel's own line to the host CPU.

There is exactly one level of preemption. A high-tier request that becomes pending while a low-tier thread runs takes over at once. The low-tier thread's channel and level move into a single shadow slot, and a context-save pulse marks the switch. When the high-tier work finishes, the shadow slot returns as the active thread with a context-restore pulse. High-tier threads are never preempted. Executing instructions and storing the register contents are handled elsewhere; this block only issues the save and restore pulses.

The controller has four states:
- `ST_IDLE`: nothing runs.
- `ST_LOW`: a low-tier thread runs.
- `ST_HIGH`: a high-tier thread runs and nothing is saved.
- `ST_NESTED`: a high-tier thread runs and a low-tier context is saved.

The transitions are:
- dispatch: from `ST_IDLE`, or on done in `ST_LOW` or `ST_HIGH`, to `ST_LOW`, `ST_HIGH` or `ST_IDLE`.
- preempt: from `ST_LOW` to `ST_NESTED`.
- chain: from `ST_NESTED` to `ST_NESTED`, on done while another high-tier request is pending.
- resume: from `ST_NESTED` to `ST_LOW`, on done with no high-tier request pending.

Top module: `thread_dispatch`

## Requirements
- R1: After reset, active_vld_o, ctx_save_o, ctx_restore_o and all bits of irq_o are 0, and nothing runs until a request arrives.
- R2: A request on a channel whose level is 0 at that moment is dropped. Raising the level afterwards does not start the channel.
- R3: When no thread runs and requests of both tiers are pending, a high-tier channel (level 4 or more) starts first.
- R4: Within a tier, the pending channel with the highest level is started. Among equal levels, the lowest channel number (bit index in req_set_i, level field prio_i[3*c+2:3*c]) wins.
- R5: A low-tier request never displaces a running low-tier thread. The active channel and level stay unchanged until done_i.
- R6: While a low-tier thread runs and done_i is low, a pending high-tier request takes over on the next edge. In that same cycle ctx_save_o is 1 for exactly one cycle and the high-tier channel and level appear on the active outputs.
- R7: A running high-tier thread keeps its channel and level until done_i, whatever requests arrive.
- R8: When the preempting thread completes and no high-tier request is pending, the saved channel becomes active again with its original level. ctx_restore_o is 1 for exactly that cycle, and this happens before any pending low-tier request starts.
- R9: When the preempting thread completes while another high-tier request is pending, that request starts directly. No save or restore pulse is issued, and the saved context resumes only after the high-tier work ends.
- R10: done_i sampled high while a thread is active makes irq_o[c] 1 for exactly the next cycle, where c is the completing channel, and no other irq_o bit is set.
- R11: A thread completing in ST_LOW or ST_HIGH is followed in the same edge by the best pending channel, or by idle if none is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_set_i | input | NUM_CH | One-cycle request pulse per channel |
| prio_i | input | 3*NUM_CH | Level per channel, 3 bits each, channel 0 in the low bits |
| done_i | input | 1 | Active thread has finished |
| active_vld_o | output | 1 | A thread is active |
| active_ch_o | output | CH_W | Active channel number |
| active_lvl_o | output | 3 | Level of the active thread |
| ctx_save_o | output | 1 | One-cycle pulse: context saved at preemption |
| ctx_restore_o | output | 1 | One-cycle pulse: saved context restored |
| irq_o | output | NUM_CH | Per-channel completion interrupt pulse |

## Verification
The bench targets these corner cases:
- Ties between equal levels. A picker that scans in the wrong direction would start the higher-numbered channel.
- A low-tier request arriving while another low-tier thread runs. A design without tier gating would switch threads with no save.
- High-tier requests arriving while a high-tier thread runs, both with and without a saved context. A design that gets this wrong would chain in a restore too early or preempt a protected thread.
- A low-tier request pending at the moment the preempting thread ends. A wrong design would start that request ahead of the resumed context.
- A level-0 request followed by raising the level. A design that latched the request would later start a disabled channel.

// File: rtl/tdsp_pkg.sv
package tdsp_pkg;

    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] HIGH_TIER_MIN = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2,
        ST_NESTED = 2'd3
    } tdsp_state_e;

    function automatic logic lvl_is_high(input logic [LVL_W-1:0] lvl);
        return lvl >= HIGH_TIER_MIN;
    endfunction

    function automatic logic lvl_is_low(input logic [LVL_W-1:0] lvl);
        return (lvl != '0) && (lvl < HIGH_TIER_MIN);
    endfunction

endpackage

// File: rtl/tdsp_pending.sv
module tdsp_pending
    import tdsp_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       req_set_i,
    input  logic [NUM_CH*LVL_W-1:0] prio_i,
    input  logic                    clr_en_i,
    input  logic [CH_W-1:0]         clr_idx_i,
    output logic [NUM_CH-1:0]       pend_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [LVL_W-1:0] lvl_c;
        logic             set_ok;

        assign lvl_c  = prio_i[c*LVL_W +: LVL_W];
        assign set_ok = req_set_i[c] && (lvl_c != '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_o[c] <= 1'b0;
            end else if (set_ok) begin
                pend_o[c] <= 1'b1;
            end else if (clr_en_i && (clr_idx_i == CH_W'(c))) begin
                pend_o[c] <= 1'b0;
            end
        end

        // R2: a request carrying level 0 never marks the channel pending
        p_zero_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (req_set_i[c] && (lvl_c == '0) && !pend_o[c]) |=> !pend_o[c]);
    end

endmodule

// File: rtl/tdsp_tier_pick.sv
module tdsp_tier_pick
    import tdsp_pkg::*;
#(
    parameter int   NUM_CH    = 8,
    parameter int   CH_W      = $clog2(NUM_CH),
    parameter logic HIGH_TIER = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       pend_i,
    input  logic [NUM_CH*LVL_W-1:0] prio_i,
    output logic                    found_o,
    output logic [CH_W-1:0]         ch_o,
    output logic [LVL_W-1:0]        lvl_o
);

    always_comb begin
        logic [LVL_W-1:0] lvl_i;
        found_o = 1'b0;
        ch_o    = '0;
        lvl_o   = '0;
        lvl_i   = '0;
        // descending scan with >= lets the lower channel win a tie
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            lvl_i = prio_i[i*LVL_W +: LVL_W];
            if (pend_i[i] && (lvl_i != '0) && (lvl_is_high(lvl_i) == HIGH_TIER)
                && (!found_o || (lvl_i >= lvl_o))) begin
                found_o = 1'b1;
                ch_o    = CH_W'(i);
                lvl_o   = lvl_i;
            end
        end
    end

    // R4: a winner is always a pending, enabled channel of this tier
    p_winner_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (pend_i[ch_o] && (lvl_o != '0) && (lvl_is_high(lvl_o) == HIGH_TIER)));

endmodule

// File: rtl/tdsp_irq_gen.sv
module tdsp_irq_gen #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [CH_W-1:0]   ch_i,
    output logic [NUM_CH-1:0] irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= '0;
        end else begin
            irq_o <= '0;
            if (fire_i) begin
                irq_o[ch_i] <= 1'b1;
            end
        end
    end

    // R10: one completion line per finished thread, for a single cycle
    p_irq_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));
    p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> irq_o[$past(ch_i)]);
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> (irq_o == '0));

endmodule

// File: rtl/thread_dispatch.sv
module thread_dispatch
    import tdsp_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       req_set_i,
    input  logic [NUM_CH*LVL_W-1:0] prio_i,
    input  logic                    done_i,
    output logic                    active_vld_o,
    output logic [CH_W-1:0]         active_ch_o,
    output logic [LVL_W-1:0]        active_lvl_o,
    output logic                    ctx_save_o,
    output logic                    ctx_restore_o,
    output logic [NUM_CH-1:0]       irq_o
);

    localparam int N_TIER = 2;

    logic [NUM_CH-1:0] pend;
    logic              clr_en;
    logic [CH_W-1:0]   clr_idx;

    logic [N_TIER-1:0] t_found;
    logic [CH_W-1:0]   t_ch  [N_TIER];
    logic [LVL_W-1:0]  t_lvl [N_TIER];

    tdsp_state_e      st_q, st_d;
    logic [CH_W-1:0]  ch_q, ch_d, sv_ch_q, sv_ch_d;
    logic [LVL_W-1:0] lvl_q, lvl_d, sv_lvl_q, sv_lvl_d;
    logic             save_q, save_d, restore_q, restore_d;
    logic             fire;

    logic             sel_vld, sel_hi;
    logic [CH_W-1:0]  sel_ch;
    logic [LVL_W-1:0] sel_lvl;

    tdsp_pending #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_set_i (req_set_i),
        .prio_i    (prio_i),
        .clr_en_i  (clr_en),
        .clr_idx_i (clr_idx),
        .pend_o    (pend)
    );

    for (genvar t = 0; t < N_TIER; t++) begin : g_tier
        tdsp_tier_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W), .HIGH_TIER(t == 1)) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .pend_i  (pend),
            .prio_i  (prio_i),
            .found_o (t_found[t]),
            .ch_o    (t_ch[t]),
            .lvl_o   (t_lvl[t])
        );
    end

    // high tier always outranks low tier
    assign sel_hi  = t_found[1];
    assign sel_vld = t_found[1] | t_found[0];
    assign sel_ch  = sel_hi ? t_ch[1]  : t_ch[0];
    assign sel_lvl = sel_hi ? t_lvl[1] : t_lvl[0];
    assign clr_idx = sel_ch;

    // next-state and datapath decisions
    always_comb begin
        st_d      = st_q;
        ch_d      = ch_q;
        lvl_d     = lvl_q;
        sv_ch_d   = sv_ch_q;
        sv_lvl_d  = sv_lvl_q;
        save_d    = 1'b0;
        restore_d = 1'b0;
        clr_en    = 1'b0;
        fire      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (sel_vld) begin
                    st_d   = sel_hi ? ST_HIGH : ST_LOW;
                    ch_d   = sel_ch;
                    lvl_d  = sel_lvl;
                    clr_en = 1'b1;
                end
            end
            ST_LOW: begin
                if (done_i) begin
                    fire = 1'b1;
                    if (sel_vld) begin
                        st_d   = sel_hi ? ST_HIGH : ST_LOW;
                        ch_d   = sel_ch;
                        lvl_d  = sel_lvl;
                        clr_en = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else if (sel_hi) begin
                    st_d     = ST_NESTED;
                    sv_ch_d  = ch_q;
                    sv_lvl_d = lvl_q;
                    ch_d     = sel_ch;
                    lvl_d    = sel_lvl;
                    clr_en   = 1'b1;
                    save_d   = 1'b1;
                end
            end
            ST_HIGH: begin
                if (done_i) begin
                    fire = 1'b1;
                    if (sel_vld) begin
                        st_d   = sel_hi ? ST_HIGH : ST_LOW;
                        ch_d   = sel_ch;
                        lvl_d  = sel_lvl;
                        clr_en = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_NESTED: begin
                if (done_i) begin
                    fire = 1'b1;
                    if (sel_hi) begin
                        ch_d   = sel_ch;
                        lvl_d  = sel_lvl;
                        clr_en = 1'b1;
                    end else begin
                        st_d      = ST_LOW;
                        ch_d      = sv_ch_q;
                        lvl_d     = sv_lvl_q;
                        restore_d = 1'b1;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // output and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q      <= '0;
            lvl_q     <= '0;
            sv_ch_q   <= '0;
            sv_lvl_q  <= '0;
            save_q    <= 1'b0;
            restore_q <= 1'b0;
        end else begin
            ch_q      <= ch_d;
            lvl_q     <= lvl_d;
            sv_ch_q   <= sv_ch_d;
            sv_lvl_q  <= sv_lvl_d;
            save_q    <= save_d;
            restore_q <= restore_d;
        end
    end

    tdsp_irq_gen #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .ch_i   (ch_q),
        .irq_o  (irq_o)
    );

    assign active_vld_o  = (st_q != ST_IDLE);
    assign active_ch_o   = ch_q;
    assign active_lvl_o  = lvl_q;
    assign ctx_save_o    = save_q;
    assign ctx_restore_o = restore_q;

    // R5: a running low-tier thread is held unless a high-tier request shows up
    p_low_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_vld_o && lvl_is_low(active_lvl_o) && !done_i && !t_found[1])
        |=> ($stable(active_ch_o) && $stable(active_lvl_o)));

    // R6: a pending high-tier request takes over a low-tier thread next edge
    p_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_vld_o && lvl_is_low(active_lvl_o) && !done_i && t_found[1])
        |=> (ctx_save_o && lvl_is_high(active_lvl_o)));
    p_save_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_save_o |=> !ctx_save_o);

    // R7: a high-tier thread is never displaced before done
    p_high_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_vld_o && lvl_is_high(active_lvl_o) && !done_i)
        |=> ($stable(active_ch_o) && $stable(active_lvl_o) && !ctx_save_o && !ctx_restore_o));

    // R8: restore brings back a low-tier context, never with a save
    p_restore_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_restore_o |-> (!ctx_save_o && active_vld_o && lvl_is_low(active_lvl_o)));
    p_restore_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_restore_o |=> !ctx_restore_o);

    // R1: idle means no pulses
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active_vld_o |-> (!ctx_save_o && !ctx_restore_o));

endmodule

// File: tb/thread_dispatch_tb_top.sv
module thread_dispatch_tb_top;

    localparam int NUM_CH = 8;
    localparam int CH_W   = 3;
    localparam int LVL_W  = 3;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [LVL_W-1:0] lvl;
        logic             save;
        logic             restore;
    } run_item_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_CH-1:0]       req_set = '0;
    logic [NUM_CH*LVL_W-1:0] prio = '0;
    logic                    done = 1'b0;
    logic                    act_vld;
    logic [CH_W-1:0]         act_ch;
    logic [LVL_W-1:0]        act_lvl;
    logic                    save_p, restore_p;
    logic [NUM_CH-1:0]       irq;

    run_item_t exp_run[$];
    int        exp_irq[$];
    int        n_chk = 0;
    int        n_bad = 0;
    bit        reported = 1'b0;
    logic              prev_vld = 1'b0;
    logic [CH_W-1:0]   prev_ch = '0;

    always #5 clk = ~clk;

    thread_dispatch #(.NUM_CH(NUM_CH), .CH_W(CH_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_set_i     (req_set),
        .prio_i        (prio),
        .done_i        (done),
        .active_vld_o  (act_vld),
        .active_ch_o   (act_ch),
        .active_lvl_o  (act_lvl),
        .ctx_save_o    (save_p),
        .ctx_restore_o (restore_p),
        .irq_o         (irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // monitor: compares thread starts and interrupts against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (act_vld && (!prev_vld || act_ch != prev_ch || save_p || restore_p)) begin
                if (exp_run.size() == 0) begin
                    check(1'b0, "R4 unexpected dispatch", {act_ch, act_lvl}, 0);
                end else begin
                    run_item_t e;
                    e = exp_run.pop_front();
                    check({act_ch, act_lvl, save_p, restore_p} == e, "R4/R6/R8/R9 dispatch",
                          {act_ch, act_lvl, save_p, restore_p}, e);
                end
            end
            if (irq != '0) begin
                if (exp_irq.size() == 0) begin
                    check(1'b0, "R10 unexpected irq", irq, 0);
                end else begin
                    int c;
                    c = exp_irq.pop_front();
                    check(irq == (NUM_CH'(1) << c), "R10 irq line", irq, NUM_CH'(1) << c);
                end
            end
            prev_vld <= act_vld;
            prev_ch  <= act_ch;
        end
    end

    task automatic set_lvl(input int ch, input int lvl);
        prio[ch*LVL_W +: LVL_W] = LVL_W'(lvl);
    endtask

    task automatic push(input int ch, input int lvl, input bit sv, input bit rs);
        exp_run.push_back({CH_W'(ch), LVL_W'(lvl), sv, rs});
    endtask

    task automatic request(input logic [NUM_CH-1:0] mask);
        @(negedge clk);
        req_set = mask;
        @(negedge clk);
        req_set = '0;
    endtask

    task automatic wait_run(input int ch);
        int t;
        t = 0;
        while (!(act_vld && act_ch == CH_W'(ch)) && t < 60) begin
            @(negedge clk);
            t++;
        end
        check(t < 60, "R11 thread start", act_ch, ch);
    endtask

    task automatic finish(input int ch);
        wait_run(ch);
        exp_irq.push_back(ch);
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic hold_check(input int ch, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(act_vld && act_ch == CH_W'(ch) && !save_p, req, act_ch, ch);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!act_vld && !save_p && !restore_p && irq == '0, "R1 reset outputs",
              {act_vld, save_p, restore_p, irq}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!act_vld, "R1 idle after reset", act_vld, 0);

        // single low-tier thread
        set_lvl(2, 2);
        push(2, 2, 0, 0);
        request(8'b0000_0100);
        finish(2);

        // R2: level 0 request is dropped, raising level later does nothing
        set_lvl(5, 0);
        request(8'b0010_0000);
        repeat (4) @(negedge clk);
        check(!act_vld, "R2 level0 ignored", act_vld, 0);
        set_lvl(5, 3);
        repeat (4) @(negedge clk);
        check(!act_vld, "R2 no late start", act_vld, 0);

        // R4 tie order and R5 no low-low preemption
        set_lvl(1, 3); set_lvl(3, 3); set_lvl(0, 1); set_lvl(4, 2);
        push(1, 3, 0, 0); push(3, 3, 0, 0); push(4, 2, 0, 0); push(0, 1, 0, 0);
        request(8'b0000_1011);
        wait_run(1);
        request(8'b0001_0000);
        hold_check(1, 3, "R5 low not preempted");
        finish(1); finish(3); finish(4); finish(0);

        // R3: high before low from idle
        set_lvl(0, 1); set_lvl(7, 4);
        push(7, 4, 0, 0); push(0, 1, 0, 0);
        request(8'b1000_0001);
        finish(7); finish(0);

        // R6 preempt, R8 resume before pending low
        set_lvl(2, 1); set_lvl(6, 5); set_lvl(7, 2);
        push(2, 1, 0, 0);
        request(8'b0000_0100);
        wait_run(2);
        push(6, 5, 1, 0); push(2, 1, 0, 1); push(7, 2, 0, 0);
        request(8'b1100_0000);
        finish(6); finish(2); finish(7);

        // R7: high-tier thread not displaced
        set_lvl(4, 4); set_lvl(5, 7);
        push(4, 4, 0, 0); push(5, 7, 0, 0);
        request(8'b0001_0000);
        wait_run(4);
        request(8'b0010_0000);
        hold_check(4, 3, "R7 high not preempted");
        finish(4); finish(5);

        // R9: chained high-tier work keeps saved context
        set_lvl(0, 2); set_lvl(3, 6); set_lvl(1, 4);
        push(0, 2, 0, 0);
        request(8'b0000_0001);
        wait_run(0);
        push(3, 6, 1, 0); push(1, 4, 0, 0); push(0, 2, 0, 1);
        request(8'b0000_1000);
        wait_run(3);
        request(8'b0000_0010);
        hold_check(3, 3, "R7 nested high not preempted");
        finish(3); finish(1); finish(0);

        repeat (6) @(negedge clk);
        check(!act_vld, "R11 idle at end", act_vld, 0);
        check(exp_run.size() == 0, "R9 all dispatches seen", exp_run.size(), 0);
        check(exp_irq.size() == 0, "R10 all irqs seen", exp_irq.size(), 0);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
    end

endmodule